// File: doc/BRIEF.md
# Phase-Detector Lock Flag

This block decides whether a frequency synthesizer loop is in lock by watching the correction pulses that its phase/frequency detector sends to the charge pump. It runs on the crystal-rate clock. Each comparison period is closed by a one-cycle strobe. Within a period, the block counts for how many crystal cycles the "raise" pulse was high, and separately for how many cycles the "lower" pulse was high. A pulse that lasts at least the wide-pulse threshold (two crystal cycles by default, so longer than one crystal period) marks the period as dirty.

The flag is deliberately asymmetric. A single dirty period drops it at once. Raising it takes an unbroken run of clean periods (eight by default). With a 62.5 kHz comparison rate, loss of lock is therefore reported within one 16 µs period. Recovery is reported 128 to 144 µs after the loop settles. A controller reads the flag as the "locked" bit, bit 6, of its status byte. A value of 1 means locked.

Top module: `lkd_lock_flag`

## Requirements
- R1: After reset the lock flag is 0 and the clean-period run is empty.
- R2: If, within one period, either pulse input is high for WIDE_CYCLES (default 2) or more clock cycles, the flag is 0 in the cycle after that period's strobe. The cycle that carries the strobe is counted.
- R3: A period in which each pulse input is high for fewer than WIDE_CYCLES cycles counts as clean. This includes a period with no pulse at all.
- R4: The flag rises in the cycle after the strobe of the CLEAN_RUN-th consecutive clean period (default 8). After CLEAN_RUN-1 clean periods it is still 0.
- R5: A dirty period restarts the run. Another full CLEAN_RUN clean periods are then needed before the flag rises.
- R6: The flag changes only in the cycle after a strobe. It holds its value at every other clock edge.
- R7: The two pulse inputs are measured separately. A period with one "raise" cycle and one "lower" cycle is clean.
- R8: The cycle counts restart at every strobe. One high cycle at the end of a period followed by one at the start of the next period gives two clean periods.
- R9: While the flag is 1, further clean periods keep it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-rate clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| up_i | input | 1 | Charge-pump "raise" pulse from the phase detector |
| dn_i | input | 1 | Charge-pump "lower" pulse from the phase detector |
| period_end_i | input | 1 | One-cycle strobe marking the last cycle of a comparison period |
| lock_o | output | 1 | Lock flag: 1 means locked |

## Verification
The bench targets several corner cases:
- Exactly CLEAN_RUN-1 clean periods, then the CLEAN_RUN-th. A run counter that is off by one raises the flag one period early or one period late.
- A pulse of exactly the threshold length, and a pulse whose last cycle coincides with the strobe. A meter that ignores the strobe cycle, or that compares with the wrong bound, calls these pulses clean.
- Single "raise" and "lower" cycles in the same period, and single cycles on both sides of a strobe. A design that merges the channels, or that fails to clear the counts at the strobe, reports false loss of lock.
- Long random period streams, to catch a run counter that wraps instead of saturating and so drops the flag while the loop is locked.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

    // Outcome of one comparison period as seen by the run tracker.
    typedef enum logic [1:0] {
        VERD_NONE  = 2'd0,   // no period boundary this cycle
        VERD_CLEAN = 2'd1,   // period closed, every pulse narrow
        VERD_WIDE  = 2'd2    // period closed, some pulse too wide
    } verdict_e;

endpackage

// File: rtl/lkd_width_meter.sv
// Measures one pulse channel in clock cycles within a comparison period.
module lkd_width_meter #(
    parameter int LIMIT = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pulse_i,
    input  logic period_end_i,
    output logic wide_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } meter_t;

    meter_t st_d, st_q;
    logic [CNT_W:0] width_now;

    always_comb begin
        st_d      = st_q;
        // Width including the current cycle, so the strobe cycle counts.
        width_now = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, pulse_i};
        wide_o    = (width_now >= (CNT_W + 1)'(LIMIT));
        if (period_end_i) begin
            st_d.cnt = '0;
        end else if (pulse_i && (st_q.cnt != CNT_W'(LIMIT))) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lkd_run_tracker.sv
// Counts consecutive clean periods and holds the lock flag.
module lkd_run_tracker
    import lkd_pkg::*;
#(
    parameter int RUN_LEN = 8,
    localparam int RUN_W  = $clog2(RUN_LEN + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  verdict_e         verdict_i,
    output logic             lock_o,
    output logic [RUN_W-1:0] run_o
);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(RUN_LEN);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             lock;
    } track_t;

    track_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (verdict_i)
            VERD_WIDE: begin
                st_d.run  = '0;
                st_d.lock = 1'b0;
            end
            VERD_CLEAN: begin
                st_d.run  = (st_q.run == RUN_FULL) ? RUN_FULL
                                                   : st_q.run + RUN_W'(1);
                st_d.lock = (st_d.run == RUN_FULL);
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o = st_q.lock;
    assign run_o  = st_q.run;

endmodule

// File: rtl/lkd_lock_flag.sv
// Lock flag: fast drop on a wide pulse, slow rise after a clean run.
module lkd_lock_flag
    import lkd_pkg::*;
#(
    parameter int WIDE_CYCLES = 2,
    parameter int CLEAN_RUN   = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic up_i,
    input  logic dn_i,
    input  logic period_end_i,
    output logic lock_o
);
    localparam int NCH   = 2;
    localparam int RUN_W = $clog2(CLEAN_RUN + 1);

    logic [NCH-1:0]   pulse_vec;
    logic [NCH-1:0]   wide_vec;
    logic             wide_any;
    verdict_e         verdict;
    logic [RUN_W-1:0] run_cnt;

    assign pulse_vec = {dn_i, up_i};

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        lkd_width_meter #(
            .LIMIT(WIDE_CYCLES)
        ) u_meter (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .pulse_i      (pulse_vec[g]),
            .period_end_i (period_end_i),
            .wide_o       (wide_vec[g])
        );
    end

    always_comb begin
        wide_any = |wide_vec;
        if (!period_end_i) begin
            verdict = VERD_NONE;
        end else if (wide_any) begin
            verdict = VERD_WIDE;
        end else begin
            verdict = VERD_CLEAN;
        end
    end

    lkd_run_tracker #(
        .RUN_LEN(CLEAN_RUN)
    ) u_track (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .verdict_i (verdict),
        .lock_o    (lock_o),
        .run_o     (run_cnt)
    );

endmodule

// File: rtl/lkd_lock_flag_chk.sv
module lkd_lock_flag_chk #(
    parameter int CLEAN_RUN = 8,
    localparam int RUN_W    = $clog2(CLEAN_RUN + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             period_end_i,
    input logic             wide_i,
    input logic [RUN_W-1:0] run_i,
    input logic             lock_i
);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(CLEAN_RUN);

    // R2: a dirty period clears the flag on the next cycle
    p_wide_drops_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_end_i && wide_i) |=> !lock_i);

    // R4: the flag only rises after a strobe that completed the run
    p_rise_after_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lock_i) |-> ($past(period_end_i) && !$past(wide_i)
                           && ($past(run_i) == RUN_FULL - RUN_W'(1))));

    // R5: the run counter never passes its full value
    p_run_bounded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i <= RUN_FULL);

    // R6: no strobe, no change of the flag
    p_flag_steady_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !period_end_i |=> $stable(lock_i));

    // R9: a clean period while locked keeps the lock
    p_clean_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_end_i && !wide_i && lock_i) |=> lock_i);

    // R4: lock implies a full run
    p_lock_full_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_i |-> (run_i == RUN_FULL));

endmodule

bind lkd_lock_flag lkd_lock_flag_chk #(
    .CLEAN_RUN(CLEAN_RUN)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .period_end_i (period_end_i),
    .wide_i       (wide_any),
    .run_i        (run_cnt),
    .lock_i       (lock_o)
);

// File: tb/sim_lkd_lock_flag.sv
`timescale 1ns/1ps
module sim_lkd_lock_flag;
    localparam int WIDE = 2;
    localparam int RUNL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up = 1'b0, dn = 1'b0, pend = 1'b0;
    logic lock;

    int checks = 0;
    int errors = 0;
    int m_run  = 0;
    bit m_lock = 1'b0;

    always #4 clk = ~clk;

    lkd_lock_flag #(.WIDE_CYCLES(WIDE), .CLEAN_RUN(RUNL)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .up_i(up), .dn_i(dn),
        .period_end_i(pend), .lock_o(lock)
    );

    // Number of high cycles of a pulse [s, s+w) that fall inside [0, len).
    function automatic int in_period(int len, int s, int w);
        int n = 0;
        for (int c = 0; c < len; c++) if (c >= s && c < s + w) n++;
        return n;
    endfunction

    function automatic bit is_wide(int len, int us, int uw, int ds, int dw);
        return (in_period(len, us, uw) >= WIDE) || (in_period(len, ds, dw) >= WIDE);
    endfunction

    task automatic check(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: lock=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One comparison period of len cycles; the strobe rides on the last cycle.
    task automatic period(int len, int us, int uw, int ds, int dw, string tag);
        bit wide = is_wide(len, us, uw, ds, dw);
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            if (c == 1) check({tag, "/R6"}, lock, m_lock);
            up   = (c >= us && c < us + uw);
            dn   = (c >= ds && c < ds + dw);
            pend = (c == len - 1);
        end
        @(negedge clk);
        up = 1'b0; dn = 1'b0; pend = 1'b0;
        if (wide) begin
            m_run = 0; m_lock = 1'b0;
        end else begin
            if (m_run < RUNL) m_run++;
            m_lock = (m_run == RUNL);
        end
        check(tag, lock, m_lock);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: lock=%0b expected finish", lock);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1 reset", lock, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", lock, 1'b0);

        // R4: seven clean periods stay unlocked, the eighth locks
        for (int i = 0; i < 7; i++) period(6, 2, 1, 0, 0, "R4 run<8");
        period(6, 0, 0, 0, 0, "R4 eighth");
        // R9: clean periods hold the lock
        period(5, 4, 1, 1, 1, "R9 hold");
        // R2: pulse of exactly WIDE cycles, ending on the strobe cycle
        period(6, 4, 2, 0, 0, "R2 edge wide");
        // R5: dirty period in the middle of a run restarts it
        for (int i = 0; i < 5; i++) period(6, 0, 1, 3, 1, "R3 clean");
        period(6, 0, 0, 1, 3, "R5 dirty");
        for (int i = 0; i < 7; i++) period(7, 6, 1, 0, 0, "R5 rerun");
        // R8: single cycles either side of a strobe (end then start)
        period(7, 0, 1, 0, 0, "R8 split");
        // R7: one raise and one lower cycle in one period are clean
        period(5, 1, 1, 2, 1, "R7 separate");
        period(5, 3, 1, 3, 1, "R7 overlap");

        for (int i = 0; i < 400; i++) begin
            int len = 3 + int'($urandom % 10);
            int us = int'($urandom % len);
            int ds = int'($urandom % len);
            int uw = ($urandom % 6 == 0) ? 2 + int'($urandom % 3) : int'($urandom % 2);
            int dw = ($urandom % 6 == 0) ? 2 + int'($urandom % 3) : int'($urandom % 2);
            period(len, us, uw, ds, dw, "R2/R3/R4 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule